// File: doc/BRIEF.md
# Per-Domain Master Permission Checker

This block decides whether a single bus access, issued by one of a small set of bus masters against a page that has already been translated, may proceed. The page entry word that came back from translation carries a 4-bit authority index. The index picks one of sixteen permission domains. Each domain holds, for every master, one bit that refuses reads and one bit that refuses writes. Software programs these bits through a small word-addressed register port. Two domains share each 32-bit register word.

The decision is combinational. It is made in the same cycle as the request, so the request side has no back-pressure: a request is judged in the cycle in which `acc_valid` is high, and no ready signal exists. When a master is refused, the block records the refusal on the next clock edge. It raises that master's status bit and, if that bit was clear, latches the faulting virtual address and the full entry word into that master's private error registers. An interrupt line is the OR of the status bits that are enabled. Software clears status bits by writing ones to a clear register.

Top module: `perm_guard`

## Requirements
- R1: After reset, every deny bit, every status bit, every enable bit and every error latch is zero. Every access from a master id below 6 is then granted, whatever authority index it carries.
- R2: Domain d is held in register word d/2, counting from word 0x00. Even domains sit in bits 15:0 and odd domains in bits 31:16. Within a domain's half, master m refuses reads at bit 2m and writes at bit 2m+1. Bits 15:12 and 31:28 are not stored and read as 0.
- R3: The domain is taken from bits 7:4 of `acc_entry`. In the same cycle, `acc_grant` is `acc_valid` with the selected deny bit clear, and `acc_fault` is `acc_valid` with that bit set. Neither output is high while `acc_valid` is low.
- R4: A request whose master id is 6 or above is always faulted. It changes no status bit and no latch.
- R5: A refused access by master m sets status bit m, at word 0x0A bit m, on the clock edge that ends the request cycle.
- R6: On that edge, if status bit m was clear, error-address word 0x10+m takes `acc_vaddr` and error-data word 0x18+m takes `acc_entry`. While the bit stays set, later refusals by m leave both words unchanged.
- R7: Writing word 0x09 clears every status bit whose write-data bit is 1. Word 0x09 reads as 0. If a clear of bit m and a refusal by m fall in the same cycle, the bit stays set and the latches take the new refusal.
- R8: Enable word 0x08 stores bits 5:0, 16 and 17, and all its other bits read 0. `irq` is high exactly when some status bit and its enable bit are both set, so it rises one cycle after an enabled refusal.
- R9: Writes to the status word are ignored. Reads of unmapped words, including the error slots of masters 6 and 7 (0x16, 0x17, 0x1E, 0x1F), return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 6 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, combinational from `cfg_addr` |
| acc_valid | input | 1 | Access request present this cycle |
| acc_master | input | 3 | Requesting master id |
| acc_write | input | 1 | 1 for a write access, 0 for a read |
| acc_vaddr | input | 32 | Virtual address of the access |
| acc_entry | input | 32 | Page entry word; bits 7:4 select the domain |
| acc_grant | output | 1 | Access allowed |
| acc_fault | output | 1 | Access refused |
| irq | output | 1 | Enabled permission fault pending |

## Verification
A software clear of a master's status bit and a fresh refusal by the same master can meet on one clock edge. The bench provokes this by driving a write of the clear word and a denied request for that master in a single cycle, after the bit has been set by an earlier refusal. It then reads the status word and the error latches back. It judges the result against the rule that the refusal wins: the bit stays set and the latches hold the new address and entry rather than the stale ones.

// File: rtl/perm_pkg.sv
package perm_pkg;
  localparam int unsigned CSR_AW        = 6;
  localparam int unsigned DOM_HALF_W    = 16;
  localparam int unsigned ENTRY_DOM_LSB = 4;

  localparam logic [CSR_AW-1:0] A_IRQ_EN   = 6'h08;
  localparam logic [CSR_AW-1:0] A_IRQ_CLR  = 6'h09;
  localparam logic [CSR_AW-1:0] A_IRQ_STAT = 6'h0A;
  localparam logic [CSR_AW-1:0] A_ERR_ADDR = 6'h10;
  localparam logic [CSR_AW-1:0] A_ERR_DATA = 6'h18;

  localparam int unsigned EN_HI_LSB = 16;

  typedef enum logic {
    DIR_RD = 1'b0,
    DIR_WR = 1'b1
  } acc_dir_e;
endpackage

// File: rtl/perm_domain_regs.sv
module perm_domain_regs #(
  parameter int unsigned NUM_DOM = 16,
  parameter int unsigned NUM_M   = 6,
  localparam int unsigned BITS   = 2 * NUM_M,
  localparam int unsigned WORDS  = NUM_DOM / 2,
  localparam int unsigned WORD_W = $clog2(WORDS)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [WORD_W-1:0]               wr_word,
  input  logic [31:0]                     wr_data,
  input  logic [WORD_W-1:0]               rd_word,
  output logic [31:0]                     rd_data,
  output logic [NUM_DOM-1:0][BITS-1:0]    deny_o
);
  import perm_pkg::*;

  logic [BITS-1:0] deny_q [NUM_DOM];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int d = 0; d < NUM_DOM; d++) deny_q[d] <= '0;
    end else if (wr_en) begin
      for (int d = 0; d < NUM_DOM; d++) begin
        if (wr_word == WORD_W'(d / 2))
          deny_q[d] <= wr_data[(d % 2) * DOM_HALF_W +: BITS];
      end
    end
  end

  genvar gd;
  generate
    for (gd = 0; gd < NUM_DOM; gd++) begin : g_out
      assign deny_o[gd] = deny_q[gd];
    end
  endgenerate

  always_comb begin
    rd_data = '0;
    rd_data[BITS-1:0]              = deny_q[{rd_word, 1'b0}];
    rd_data[DOM_HALF_W +: BITS]    = deny_q[{rd_word, 1'b1}];
  end
endmodule

// File: rtl/perm_decide.sv
module perm_decide #(
  parameter int unsigned NUM_DOM = 16,
  parameter int unsigned NUM_M   = 6,
  parameter int unsigned MID_W   = 3,
  localparam int unsigned BITS   = 2 * NUM_M,
  localparam int unsigned DOM_W  = $clog2(NUM_DOM)
) (
  input  logic [NUM_DOM-1:0][BITS-1:0] deny_i,
  input  logic                         acc_valid,
  input  logic [MID_W-1:0]             acc_master,
  input  logic                         acc_write,
  input  logic [DOM_W-1:0]             dom,
  output logic                         grant,
  output logic                         fault,
  output logic [NUM_M-1:0]             viol_oh
);
  import perm_pkg::*;

  logic [BITS-1:0] dom_bits;
  logic            blocked;
  acc_dir_e        dir;

  assign dom_bits = deny_i[dom];
  assign dir      = acc_write ? DIR_WR : DIR_RD;

  always_comb begin
    blocked = 1'b1;
    viol_oh = '0;
    for (int m = 0; m < NUM_M; m++) begin
      if (acc_master == MID_W'(m)) begin
        blocked    = (dir == DIR_WR) ? dom_bits[2*m+1] : dom_bits[2*m];
        viol_oh[m] = acc_valid & blocked;
      end
    end
  end

  assign grant = acc_valid & ~blocked;
  assign fault = acc_valid &  blocked;
endmodule

// File: rtl/perm_fault_log.sv
module perm_fault_log #(
  parameter int unsigned NUM_M = 6,
  parameter int unsigned VA_W  = 32,
  parameter int unsigned ENT_W = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_M-1:0]              viol_oh,
  input  logic [VA_W-1:0]               vaddr,
  input  logic [ENT_W-1:0]              entry,
  input  logic                          en_wr,
  input  logic [NUM_M-1:0]              en_lo_wdata,
  input  logic [1:0]                    en_hi_wdata,
  input  logic                          clr_wr,
  input  logic [NUM_M-1:0]              clr_mask,
  output logic [NUM_M-1:0]              status,
  output logic [NUM_M-1:0]              en_lo,
  output logic [1:0]                    en_hi,
  output logic [NUM_M-1:0][VA_W-1:0]    err_addr,
  output logic [NUM_M-1:0][ENT_W-1:0]   err_data,
  output logic                          irq
);
  logic [NUM_M-1:0] clr_hit;
  logic [NUM_M-1:0] open_slot;

  assign clr_hit   = clr_wr ? clr_mask : '0;
  assign open_slot = ~status | clr_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status   <= '0;
      en_lo    <= '0;
      en_hi    <= '0;
      err_addr <= '0;
      err_data <= '0;
    end else begin
      if (en_wr) begin
        en_lo <= en_lo_wdata;
        en_hi <= en_hi_wdata;
      end
      for (int m = 0; m < NUM_M; m++) begin
        if (viol_oh[m] && open_slot[m]) begin
          err_addr[m] <= vaddr;
          err_data[m] <= entry;
        end
        if (viol_oh[m])      status[m] <= 1'b1;
        else if (clr_hit[m]) status[m] <= 1'b0;
      end
    end
  end

  assign irq = |(status & en_lo);
endmodule

// File: rtl/perm_guard.sv
module perm_guard #(
  parameter int unsigned NUM_DOMAINS = 16,
  parameter int unsigned NUM_MASTERS = 6,
  parameter int unsigned MID_W       = 3,
  parameter int unsigned ADDR_W      = 32,
  localparam int unsigned DOM_W      = $clog2(NUM_DOMAINS),
  localparam int unsigned DOM_WORDS  = NUM_DOMAINS / 2,
  localparam int unsigned WORD_W     = $clog2(DOM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [5:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              acc_valid,
  input  logic [MID_W-1:0]  acc_master,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_vaddr,
  input  logic [31:0]       acc_entry,
  output logic              acc_grant,
  output logic              acc_fault,
  output logic              irq
);
  import perm_pkg::*;

  logic                                     dom_hit;
  logic [31:0]                              dom_rdata;
  logic [NUM_DOMAINS-1:0][2*NUM_MASTERS-1:0] deny_tab;
  logic [NUM_MASTERS-1:0]                   viol_oh;
  logic [NUM_MASTERS-1:0]                   irq_status;
  logic [NUM_MASTERS-1:0]                   irq_en_lo;
  logic [1:0]                               irq_en_hi;
  logic [NUM_MASTERS-1:0][ADDR_W-1:0]       err_addr;
  logic [NUM_MASTERS-1:0][31:0]             err_data;

  assign dom_hit = (cfg_addr < CSR_AW'(DOM_WORDS));

  perm_domain_regs #(.NUM_DOM(NUM_DOMAINS), .NUM_M(NUM_MASTERS)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr && dom_hit),
    .wr_word (cfg_addr[WORD_W-1:0]),
    .wr_data (cfg_wdata),
    .rd_word (cfg_addr[WORD_W-1:0]),
    .rd_data (dom_rdata),
    .deny_o  (deny_tab)
  );

  perm_decide #(.NUM_DOM(NUM_DOMAINS), .NUM_M(NUM_MASTERS), .MID_W(MID_W)) u_decide (
    .deny_i     (deny_tab),
    .acc_valid  (acc_valid),
    .acc_master (acc_master),
    .acc_write  (acc_write),
    .dom        (acc_entry[ENTRY_DOM_LSB +: DOM_W]),
    .grant      (acc_grant),
    .fault      (acc_fault),
    .viol_oh    (viol_oh)
  );

  perm_fault_log #(.NUM_M(NUM_MASTERS), .VA_W(ADDR_W), .ENT_W(32)) u_log (
    .clk         (clk),
    .rst_n       (rst_n),
    .viol_oh     (viol_oh),
    .vaddr       (acc_vaddr),
    .entry       (acc_entry),
    .en_wr       (cfg_wr && cfg_addr == A_IRQ_EN),
    .en_lo_wdata (cfg_wdata[NUM_MASTERS-1:0]),
    .en_hi_wdata (cfg_wdata[EN_HI_LSB +: 2]),
    .clr_wr      (cfg_wr && cfg_addr == A_IRQ_CLR),
    .clr_mask    (cfg_wdata[NUM_MASTERS-1:0]),
    .status      (irq_status),
    .en_lo       (irq_en_lo),
    .en_hi       (irq_en_hi),
    .err_addr    (err_addr),
    .err_data    (err_data),
    .irq         (irq)
  );

  always_comb begin
    cfg_rdata = '0;
    if (dom_hit) begin
      cfg_rdata = dom_rdata;
    end else if (cfg_addr == A_IRQ_EN) begin
      cfg_rdata[NUM_MASTERS-1:0]  = irq_en_lo;
      cfg_rdata[EN_HI_LSB +: 2]   = irq_en_hi;
    end else if (cfg_addr == A_IRQ_STAT) begin
      cfg_rdata[NUM_MASTERS-1:0]  = irq_status;
    end else begin
      for (int m = 0; m < NUM_MASTERS; m++) begin
        if (cfg_addr == A_ERR_ADDR + CSR_AW'(m)) cfg_rdata = 32'(err_addr[m]);
        if (cfg_addr == A_ERR_DATA + CSR_AW'(m)) cfg_rdata = err_data[m];
      end
    end
  end
endmodule

// File: rtl/perm_guard_chk.sv
module perm_guard_chk #(
  parameter int unsigned NUM_M = 6,
  parameter int unsigned MID_W = 3,
  parameter int unsigned VA_W  = 32
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        acc_valid,
  input logic [MID_W-1:0]            acc_master,
  input logic                        acc_grant,
  input logic                        acc_fault,
  input logic                        cfg_wr,
  input logic [5:0]                  cfg_addr,
  input logic [31:0]                 cfg_wdata,
  input logic                        irq,
  input logic [NUM_M-1:0]            status,
  input logic [NUM_M-1:0]            en_lo,
  input logic [NUM_M-1:0][VA_W-1:0]  err_addr,
  input logic [NUM_M-1:0][31:0]      err_data
);
  import perm_pkg::*;

  logic clr_wr;
  assign clr_wr = cfg_wr && (cfg_addr == A_IRQ_CLR);

  assert_grant_fault_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_grant && acc_fault));

  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> (!acc_grant && !acc_fault));

  assert_bad_master_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_master >= MID_W'(NUM_M)) |-> acc_fault);

  assert_bad_master_nostat_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_master >= MID_W'(NUM_M) && !clr_wr) |=> $stable(status));

  genvar gm;
  generate
    for (gm = 0; gm < NUM_M; gm++) begin : g_m
      assert_status_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_fault && acc_master == MID_W'(gm)) |=> status[gm]);

      assert_latch_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (status[gm] && !(clr_wr && cfg_wdata[gm]))
        |=> ($stable(err_addr[gm]) && $stable(err_data[gm])));

      assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && cfg_wdata[gm] && !(acc_valid && acc_fault && acc_master == MID_W'(gm)))
        |=> !status[gm]);

      assert_irq_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(status[gm]) && en_lo[gm]) |-> irq);
    end
  endgenerate
endmodule

bind perm_guard perm_guard_chk #(.NUM_M(NUM_MASTERS), .MID_W(MID_W), .VA_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_valid  (acc_valid),
  .acc_master (acc_master),
  .acc_grant  (acc_grant),
  .acc_fault  (acc_fault),
  .cfg_wr     (cfg_wr),
  .cfg_addr   (cfg_addr),
  .cfg_wdata  (cfg_wdata),
  .irq        (irq),
  .status     (irq_status),
  .en_lo      (irq_en_lo),
  .err_addr   (err_addr),
  .err_data   (err_data)
);

// File: tb/tb_perm_guard.sv
module tb_perm_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        acc_valid = 1'b0;
  logic [2:0]  acc_master = '0;
  logic        acc_write = 1'b0;
  logic [31:0] acc_vaddr = '0;
  logic [31:0] acc_entry = '0;
  logic        acc_grant, acc_fault, irq;

  int n_chk = 0;
  int n_fail = 0;
  bit programmed = 0;
  logic [5:0]  ms = '0;
  logic [31:0] mea [6];
  logic [31:0] med [6];

  always #10 clk = ~clk;

  perm_guard dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_valid(acc_valid),
    .acc_master(acc_master), .acc_write(acc_write), .acc_vaddr(acc_vaddr),
    .acc_entry(acc_entry), .acc_grant(acc_grant), .acc_fault(acc_fault), .irq(irq)
  );

  function automatic logic [11:0] pat(input int d);
    return 12'(((d * 37 + 5) ^ (d << 7)) & 12'hFFF);
  endfunction

  function automatic bit exp_deny(input int m, input bit w, input int d);
    logic [11:0] p;
    if (m >= 6) return 1'b1;
    if (!programmed) return 1'b0;
    p = pat(d);
    return p[2*m + int'(w)];
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one cycle: optional register write and optional access, checked and modelled
  task automatic step(input bit dw, input logic [5:0] a, input logic [31:0] wd,
                      input bit da, input int m, input bit w,
                      input logic [31:0] va, input logic [31:0] ent, input string tag);
    bit dn;
    logic [5:0] clr;
    @(negedge clk);
    cfg_wr = dw; cfg_addr = a; cfg_wdata = wd;
    acc_valid = da; acc_master = 3'(m); acc_write = w; acc_vaddr = va; acc_entry = ent;
    #2;
    dn = exp_deny(m, w, int'(ent[7:4]));
    if (da) begin
      check({tag, " grant"}, 32'(acc_grant), 32'(!dn));
      check({tag, " fault"}, 32'(acc_fault), 32'(dn));
    end
    @(posedge clk);
    #1;
    cfg_wr = 1'b0; acc_valid = 1'b0;
    clr = (dw && a == 6'h09) ? wd[5:0] : 6'h00;
    if (da && dn && m < 6) begin
      if (!ms[m] || clr[m]) begin mea[m] = va; med[m] = ent; end
    end
    ms = ms & ~clr;
    if (da && dn && m < 6) ms[m] = 1'b1;
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    cfg_addr = a;
    #2;
    check(tag, cfg_rdata, exp);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    int tgt;
    for (int i = 0; i < 6; i++) begin mea[i] = '0; med[i] = '0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    for (int w = 0; w < 8; w++) rd(6'(w), 32'h0, "R1 domain word");
    rd(6'h08, 32'h0, "R1 enable");
    rd(6'h0A, 32'h0, "R1 status");
    rd(6'h10, 32'h0, "R1 err addr");
    for (int m = 0; m < 6; m++) step(0, 0, 0, 1, m, 1'b1, 32'h100, 32'h50, "R1 open access");
    check("R1 irq", 32'(irq), 32'h0);

    // R2: program all domains with reserved bits set, read back
    for (int w = 0; w < 8; w++)
      step(1, 6'(w), {4'hF, pat(2*w+1), 4'hF, pat(2*w)}, 0, 0, 0, 0, 0, "R2 write");
    programmed = 1;
    for (int w = 0; w < 8; w++)
      rd(6'(w), {4'h0, pat(2*w+1), 4'h0, pat(2*w)}, "R2 readback");

    // R3/R4: sweep every domain, master id and direction
    for (int d = 0; d < 16; d++)
      for (int m = 0; m < 8; m++)
        for (int w = 0; w < 2; w++)
          step(0, 0, 0, 1, m, w[0], 32'h1000_0000 + 32'(d) * 4096 + 32'(m) * 16 + 32'(w),
               {20'hABCDE ^ 20'(d), 4'h0, 4'(d), 4'h2}, (m >= 6) ? "R4 sweep" : "R3 sweep");
    step(0, 0, 0, 0, 0, 0, 0, 32'h30, "R3 idle");
    check("R3 idle grant", 32'(acc_grant), 32'h0);

    // R5/R6: status and first-violation latches
    rd(6'h0A, 32'(ms), "R5 status");
    for (int m = 0; m < 6; m++) begin
      rd(6'h10 + 6'(m), mea[m], "R6 err addr");
      rd(6'h18 + 6'(m), med[m], "R6 err data");
    end

    // R9: status write ignored, unmapped reads
    step(1, 6'h0A, 32'h0, 0, 0, 0, 0, 0, "R9 stat write");
    rd(6'h0A, 32'(ms), "R9 status unchanged");
    rd(6'h0B, 32'h0, "R9 unmapped 0B");
    rd(6'h16, 32'h0, "R9 slot m6 addr");
    rd(6'h1F, 32'h0, "R9 slot m7 data");
    rd(6'h3F, 32'h0, "R9 unmapped 3F");

    // R7: clear
    step(1, 6'h09, 32'h0000_0003, 0, 0, 0, 0, 0, "R7 clear");
    rd(6'h0A, 32'(ms), "R7 status after clear");
    rd(6'h09, 32'h0, "R7 clear reads 0");

    // R7: clear and violation of master 2 in one cycle
    tgt = -1;
    for (int d = 15; d >= 0; d--) if (pat(d) & 12'h020) tgt = d;
    if (!ms[2]) step(0, 0, 0, 1, 2, 1'b1, 32'h1, {24'h0, 4'(tgt), 4'h2}, "R7 prime");
    step(1, 6'h09, 32'h0000_0004, 1, 2, 1'b1, 32'hCAFE_2000, {24'h777, 4'(tgt), 4'h2}, "R7 collide");
    rd(6'h0A, 32'(ms), "R7 collide status");
    rd(6'h12, 32'hCAFE_2000, "R7 collide latch addr");
    rd(6'h1A, {24'h777, 4'(tgt), 4'h2}, "R7 collide latch data");
    // R6: second violation with bit set does not overwrite
    step(0, 0, 0, 1, 2, 1'b1, 32'hDEAD_0000, {24'h111, 4'(tgt), 4'h2}, "R6 hold");
    rd(6'h12, 32'hCAFE_2000, "R6 hold addr");

    // R8: enable register and irq
    step(1, 6'h08, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, "R8 en write");
    rd(6'h08, 32'h0003_003F, "R8 enable readback");
    check("R8 irq on", 32'(irq), 32'(|ms));
    step(1, 6'h09, 32'h3F, 0, 0, 0, 0, 0, "R8 clear all");
    check("R8 irq off", 32'(irq), 32'h0);
    step(1, 6'h08, 32'h0000_0010, 0, 0, 0, 0, 0, "R8 en m4");
    tgt = -1;
    for (int d = 15; d >= 0; d--) if (pat(d) & 12'h100) tgt = d;
    step(0, 0, 0, 1, 4, 1'b0, 32'h44, {24'h0, 4'(tgt), 4'h0}, "R8 m4 fault");
    check("R8 irq rises", 32'(irq), 32'h1);
    step(1, 6'h09, 32'h10, 0, 0, 0, 0, 0, "R8 clear m4");
    check("R8 irq falls", 32'(irq), 32'h0);
    tgt = -1;
    for (int d = 15; d >= 0; d--) if (pat(d) & 12'h004) tgt = d;
    step(0, 0, 0, 1, 1, 1'b0, 32'h11, {24'h0, 4'(tgt), 4'h0}, "R8 m1 masked");
    check("R8 masked no irq", 32'(irq), 32'h0);
    rd(6'h0A, 32'(ms), "R8 masked status");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule